// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This combinational unit adds or subtracts two operands held in sign-magnitude form. Each operand is a sign bit plus an unsigned magnitude of `MAG_W` bits. A single control input chooses between addition and subtraction. Subtraction is performed by flipping the sign of the second operand and then applying the addition rules.

The unit first decides whether the two effective signs agree. If they agree, the magnitudes are summed and the result keeps the shared sign. A carry out of the top magnitude bit raises the overflow flag. If the signs disagree, a comparator picks the larger magnitude and steers it to the minuend side of the subtractor. The smaller magnitude is then taken away from it, and the result takes the sign of the larger operand. This path can never overflow.

Zero has two encodings on the inputs, and both are accepted. On the output a zero magnitude always carries a positive sign. Negative zero is therefore never produced.

Top module: `sm_addsub`

## Requirements
- R1: A sign bit of 0 means positive and 1 means negative. The magnitude is an unsigned `MAG_W`-bit value (default 7). The result over all sign, magnitude and operation combinations equals the arithmetic value of A plus or minus B, wrapped as in R2 and R3.
- R2: When the effective signs agree, the result magnitude is (a_mag + b_mag) mod 2^MAG_W. The result sign is the common sign, unless the magnitude is zero.
- R3: When the effective signs agree and a_mag + b_mag ≥ 2^MAG_W, the overflow output is 1. Otherwise it is 0.
- R4: When the effective signs differ, the result magnitude is |a_mag − b_mag| and the overflow output is 0.
- R5: When the effective signs differ, the result sign is the effective sign of the operand with the larger magnitude.
- R6: With op_sub = 1, the effective sign of B is the inverse of b_sign, and R2 to R5 apply unchanged.
- R7: Whenever the result magnitude is zero, the result sign is 0. This includes an overflowing sum that wraps to zero.
- R8: Equal magnitudes with differing effective signs give +0 with the overflow output clear.
- R9: An input magnitude of zero acts as zero whichever its sign bit is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | MAG_W | Magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | MAG_W | Magnitude of operand B |
| op_sub | input | 1 | 0 = A + B, 1 = A − B |
| res_sign | output | 1 | Sign of the result |
| res_mag | output | MAG_W | Magnitude of the result |
| ovf | output | 1 | Magnitude carry out on the add path |

## Verification
Two functions can act on the same evaluation: the overflow report and the forcing of a zero result to positive. This happens when a sum of like-signed magnitudes wraps exactly to zero, for example −127 + −1 or 64 + 64. Such vectors are placed in the table, and the bench expects overflow set, magnitude zero and a positive sign all together. A second pairing is tested by cancelling equal magnitudes through the subtract control. There the sign inversion, the larger-operand choice and the zero forcing all act on one result, and only +0 with no overflow is accepted.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // which operation the magnitude datapath performs
  typedef enum logic {
    PATH_ADD = 1'b0,
    PATH_SUB = 1'b1
  } sm_path_e;
endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] x_mag,
  input  logic [W-1:0] y_mag,
  output logic         x_ge_y
);
  // chain from LSB upward: a higher differing bit overrides the lower verdict
  logic [W:0] ge_chain;

  assign ge_chain[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_cmp_bit
    assign ge_chain[i+1] = (x_mag[i] & ~y_mag[i]) |
                           (~(x_mag[i] ^ y_mag[i]) & ge_chain[i]);
  end

  assign x_ge_y = ge_chain[W];
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit
  import sm_pkg::*;
#(
  parameter int W = 7
) (
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  input  logic         a_ge_b,
  input  sm_path_e     path,
  output logic [W-1:0] mag_out,
  output logic         add_carry
);
  logic [W-1:0] big_mag;
  logic [W-1:0] small_mag;
  logic [W-1:0] rhs;
  logic [W:0]   carry;

  // put the larger magnitude on the minuend side
  always_comb begin
    if (a_ge_b) begin
      big_mag   = a_mag;
      small_mag = b_mag;
    end else begin
      big_mag   = b_mag;
      small_mag = a_mag;
    end
  end

  // subtract: big + ~small + 1 ; add: big + small
  assign rhs      = (path == PATH_SUB) ? ~small_mag : small_mag;
  assign carry[0] = (path == PATH_SUB);

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign mag_out[i]  = big_mag[i] ^ rhs[i] ^ carry[i];
    assign carry[i+1]  = (big_mag[i] & rhs[i]) |
                         ((big_mag[i] ^ rhs[i]) & carry[i]);
  end

  assign add_carry = (path == PATH_ADD) & carry[W];

  always_comb begin
    if (!$isunknown({a_mag, b_mag, a_ge_b, path}) && path == PATH_SUB) begin
      // R4
      sub_no_borrow_chk: assert (carry[W] == 1'b1)
        else $error("subtract path borrowed: comparator and swap disagree");
      // R4
      sub_range_chk: assert (mag_out <= big_mag)
        else $error("difference exceeds larger magnitude");
    end
  end
endmodule

// File: rtl/sm_sign_sel.sv
module sm_sign_sel
  import sm_pkg::*;
(
  input  logic     a_sign,
  input  logic     b_eff_sign,
  input  logic     a_ge_b,
  input  sm_path_e path,
  input  logic     mag_zero,
  output logic     res_sign
);
  logic raw_sign;

  always_comb begin
    if (path == PATH_ADD) begin
      raw_sign = a_sign;
    end else if (a_ge_b) begin
      raw_sign = a_sign;
    end else begin
      raw_sign = b_eff_sign;
    end
  end

  assign res_sign = raw_sign & ~mag_zero;

  always_comb begin
    if (!$isunknown({mag_zero, res_sign})) begin
      // R7
      zero_positive_chk: assert (!(mag_zero && res_sign))
        else $error("negative zero produced");
    end
  end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             op_sub,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             ovf
);
  localparam int SUM_W = MAG_W + 1;

  logic     b_eff_sign;
  sm_path_e path;
  logic     a_ge_b;
  logic     mag_zero;

  assign b_eff_sign = b_sign ^ op_sub;
  assign path       = (a_sign == b_eff_sign) ? PATH_ADD : PATH_SUB;

  sm_mag_cmp #(.W(MAG_W)) u_cmp (
    .x_mag  (a_mag),
    .y_mag  (b_mag),
    .x_ge_y (a_ge_b)
  );

  sm_mag_unit #(.W(MAG_W)) u_mag (
    .a_mag     (a_mag),
    .b_mag     (b_mag),
    .a_ge_b    (a_ge_b),
    .path      (path),
    .mag_out   (res_mag),
    .add_carry (ovf)
  );

  assign mag_zero = (res_mag == '0);

  sm_sign_sel u_sign (
    .a_sign     (a_sign),
    .b_eff_sign (b_eff_sign),
    .a_ge_b     (a_ge_b),
    .path       (path),
    .mag_zero   (mag_zero),
    .res_sign   (res_sign)
  );

  always_comb begin
    if (!$isunknown({a_sign, a_mag, b_sign, b_mag, op_sub, res_mag, ovf, res_sign})) begin
      if (path == PATH_ADD) begin
        // R3
        add_total_chk: assert ({ovf, res_mag} ==
                               ({1'b0, a_mag} + SUM_W'(b_mag)))
          else $error("add path total mismatch");
      end else begin
        // R4
        no_overflow_chk: assert (!ovf)
          else $error("overflow raised on subtract path");
        if (a_mag == b_mag) begin
          // R8
          cancel_zero_chk: assert (res_mag == '0 && !res_sign)
            else $error("equal magnitudes did not cancel to +0");
        end
      end
    end
  end
endmodule

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 7;
  localparam int LIM = 1 << MW;
  localparam int NV = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          a_sign, b_sign, op_sub;
  logic [MW-1:0] a_mag, b_mag;
  logic          res_sign, ovf;
  logic [MW-1:0] res_mag;

  int tests = 0;
  int fails = 0;

  sm_addsub #(.MAG_W(MW)) u0 (
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .op_sub(op_sub), .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf)
  );

  // {a_s, a_m[7], b_s, b_m[7], op, exp_s, exp_m[7], exp_ovf}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,7'd5,  1'b0,7'd3,  1'b0, 1'b0,7'd8,  1'b0},  // R2 +5 + +3
    {1'b1,7'd5,  1'b1,7'd3,  1'b0, 1'b1,7'd8,  1'b0},  // R2 -5 + -3
    {1'b0,7'd100,1'b0,7'd50, 1'b0, 1'b0,7'd22, 1'b1},  // R3 wrap
    {1'b1,7'd127,1'b1,7'd1,  1'b0, 1'b0,7'd0,  1'b1},  // R3 R7 wrap to zero
    {1'b0,7'd10, 1'b1,7'd3,  1'b0, 1'b0,7'd7,  1'b0},  // R4
    {1'b0,7'd3,  1'b1,7'd10, 1'b0, 1'b1,7'd7,  1'b0},  // R5 B larger
    {1'b1,7'd20, 1'b0,7'd5,  1'b0, 1'b1,7'd15, 1'b0},  // R5 A larger
    {1'b1,7'd5,  1'b0,7'd20, 1'b0, 1'b0,7'd15, 1'b0},  // R5
    {1'b0,7'd9,  1'b0,7'd4,  1'b1, 1'b0,7'd5,  1'b0},  // R6 +9 - +4
    {1'b0,7'd4,  1'b0,7'd9,  1'b1, 1'b1,7'd5,  1'b0},  // R6 +4 - +9
    {1'b0,7'd60, 1'b1,7'd70, 1'b1, 1'b0,7'd2,  1'b1},  // R6 R3
    {1'b1,7'd8,  1'b1,7'd8,  1'b1, 1'b0,7'd0,  1'b0},  // R8 via subtract
    {1'b0,7'd33, 1'b1,7'd33, 1'b0, 1'b0,7'd0,  1'b0},  // R8
    {1'b1,7'd0,  1'b0,7'd12, 1'b0, 1'b0,7'd12, 1'b0},  // R9 -0 + +12
    {1'b1,7'd0,  1'b1,7'd0,  1'b0, 1'b0,7'd0,  1'b0},  // R9 R7
    {1'b0,7'd0,  1'b0,7'd0,  1'b1, 1'b0,7'd0,  1'b0},  // R7
    {1'b1,7'd0,  1'b1,7'd7,  1'b0, 1'b1,7'd7,  1'b0},  // R9 -0 + -7
    {1'b0,7'd127,1'b0,7'd0,  1'b0, 1'b0,7'd127,1'b0},  // R2 edge no carry
    {1'b0,7'd127,1'b1,7'd0,  1'b1, 1'b0,7'd127,1'b0},  // R9 R6
    {1'b1,7'd127,1'b0,7'd127,1'b0, 1'b0,7'd0,  1'b0}   // R8 full scale
  };

  task automatic drive(input logic as, input logic [MW-1:0] am,
                       input logic bs, input logic [MW-1:0] bm, input logic op);
    @(negedge clk);
    a_sign = as; a_mag = am; b_sign = bs; b_mag = bm; op_sub = op;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic es,
                       input logic [MW-1:0] em, input logic eo);
    tests++;
    if (res_sign !== es || res_mag !== em || ovf !== eo) begin
      fails++;
      $display("FAIL %s: got sign=%0b mag=%0d ovf=%0b, expected sign=%0b mag=%0d ovf=%0b",
               tag, res_sign, res_mag, ovf, es, em, eo);
    end
  endtask

  initial begin
    a_sign = 1'b0; a_mag = '0; b_sign = 1'b0; b_mag = '0; op_sub = 1'b0;
    @(posedge clk);
    #1;
    check("R1 idle inputs give +0", 1'b0, '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25], VEC[i][24:18], VEC[i][17], VEC[i][16:10], VEC[i][9]);
      check($sformatf("table row %0d", i), VEC[i][8], VEC[i][7:1], VEC[i][0]);
    end

    // R1 arithmetic model sweep, computed from signed integer values
    for (int am = 0; am < LIM; am += 9) begin
      for (int bm = 0; bm < LIM; bm += 13) begin
        for (int k = 0; k < 8; k++) begin
          int va, vb, r, mag;
          logic s, o;
          va = k[0] ? -am : am;
          vb = k[1] ? -bm : bm;
          r  = k[2] ? va - vb : va + vb;
          mag = (r < 0) ? -r : r;
          o = (mag >= LIM);
          if (o) mag = mag - LIM;
          s = (r < 0) && (mag != 0);
          drive(k[0], MW'(am), k[1], MW'(bm), k[2]);
          check("R1 model sweep", s, MW'(mag), o);
        end
      end
    end

    // R3 carry exactly at the boundary, R7 with it
    drive(1'b0, 7'd64, 1'b0, 7'd64, 1'b0);
    check("R3 R7 64+64", 1'b0, 7'd0, 1'b1);
    drive(1'b0, 7'd64, 1'b0, 7'd63, 1'b0);
    check("R3 127 no carry", 1'b0, 7'd127, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule